// File: doc/BRIEF.md
# Serial Half-Bridge Switch Controller

This block is the digital front end of a three-channel half-bridge driver. A host talks to it over a 16-bit SPI-style link. The link uses an active-low select, a serial clock, a data input and a data output. Every frame moves a command word into the block and a status word out of it at the same time. Both words travel least significant bit first.

The command says which low-side and high-side switches should conduct and whether overcurrent shutdown is armed. It can also ask for the sticky fault flags to be wiped. A received command only reaches the outputs when the select line is released, and only if the frame held exactly sixteen bits.

The serial pins are asynchronous to the system clock. They pass through a parameterised synchronizer, and the block works on the edges it detects in the synchronized signals. The fault inputs arrive as one-cycle pulses from the analog side and are latched until the host clears them.

Top module: `hbctl_top`

## Requirements
- R1: After reset, all `ls_on` and `hs_on` bits are 0, `ocs_en` is 0, `sdo_en` is 0, and the three fault latches read back as 0 in the next frame.
- R2: `sdi` is sampled on falling `sck` edges, least significant bit first. In the command word, bit 1+2b drives `ls_on[b]` and bit 2+2b drives `hs_on[b]` (b = 0..2), and a 1 turns the switch on.
- R3: `ls_on`, `hs_on` and `ocs_en` change only when `cs_n` is released after a valid frame. Until then they keep their previous values.
- R4: A frame whose falling-`sck` count at the release of `cs_n` is not exactly 16 leaves every output unchanged. This holds for both shorter and longer frames.
- R5: If a command sets both bits of the same bridge, both `ls_on[b]` and `hs_on[b]` go to 0.
- R6: Command bit 13 sets `ocs_en`.
- R7: Command bits 7 to 12, 14 and 15 have no effect on any output.
- R8: The status word is captured when `cs_n` falls and is shifted out on `sdo` LSB first. `sdo` advances on rising `sck` edges, except the first rising edge of a frame. The status word is laid out as follows: bit 0 is `temp_warn`; bit 1+k is `out_fb[k]`; bit 13 is the short-circuit latch; bit 14 is the open-load latch; bit 15 is the supply-fault latch; all other bits are 0.
- R9: `sdo_en` is 0 while `cs_n` is high and 1 during a frame.
- R10: A one-cycle pulse on `sc_evt`, `ol_evt` or `psf_evt` sets its latch, and the latch stays set across frames.
- R11: A committed command with bit 0 set clears all three fault latches.
- R12: A fault pulse in the same cycle as a clear leaves its latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial status data |
| sdo_en | output | 1 | Output enable for the `sdo` pad driver |
| ls_on | output | 3 | Low-side switch enables, one per bridge |
| hs_on | output | 3 | High-side switch enables, one per bridge |
| ocs_en | output | 1 | Overcurrent shutdown armed |
| sc_evt | input | 1 | Short-circuit fault pulse |
| ol_evt | input | 1 | Open-load fault pulse |
| psf_evt | input | 1 | Supply-fault pulse |
| temp_warn | input | 1 | Live temperature prewarning level |
| out_fb | input | 6 | Live switch state feedback: low, then high, per bridge |

## Verification
The assertions check four things on every cycle. No bridge ever has both switches on. The switch outputs change only in the cycle after a commit. The fault latches hold unless a clear occurs, are set by a pulse and are emptied by a clear. `sdo` moves only after a rising serial clock, and its enable only rises after a select fall. Other behaviours are visible only through the bench's scenarios: the exact bit mapping of both words, the discarding of 15-bit and 17-bit frames, the ignored bits, and the read-back of latched faults in a later frame.

// File: rtl/hbctl_pkg.sv
package hbctl_pkg;
   // command word fields (the shift order is LSB first)
   localparam int CMD_CLR       = 0;
   localparam int CMD_BR_BASE   = 1;
   localparam int CMD_OCS       = 13;
   localparam int CMD_LAST_FREE = 12;
   // status word fields
   localparam int ST_TEMP       = 0;
   localparam int ST_FB_BASE    = 1;
   localparam int ST_SC         = 13;
   localparam int ST_OL         = 14;
   localparam int ST_PSF        = 15;
   localparam int WORD_W        = 16;
   localparam int N_FAULT       = 3;
endpackage

// File: rtl/hbctl_sync.sv
module hbctl_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("hbctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[s] <= RST_VAL;
         else if (s == 0) stage[s] <= d;
         else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/hbctl_shifter.sv
module hbctl_shifter #(
   parameter int W = 16,
   parameter int CW = $clog2(W + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_fall,
   input  logic          cs_rise,
   input  logic          sck_fall,
   input  logic          sck_rise,
   input  logic          sdi_s,
   input  logic [W-1:0]  status_in,
   output logic [W-1:0]  rx_word,
   output logic [CW-1:0] bit_cnt,
   output logic          sdo,
   output logic          active
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic [W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_word <= '0;
         bit_cnt <= '0;
         active  <= 1'b0;
      end else if (cs_fall) begin
         tx_q    <= status_in;
         bit_cnt <= '0;
         active  <= 1'b1;
      end else if (cs_rise) begin
         active  <= 1'b0;
      end else if (active) begin
         if (sck_fall) begin
            rx_word <= {sdi_s, rx_word[W-1:1]};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         end
         if (sck_rise && bit_cnt != '0) tx_q <= {1'b0, tx_q[W-1:1]};
      end
   end

   assign sdo = tx_q[0];
endmodule

// File: rtl/hbctl_sticky.sv
module hbctl_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else q[i] <= set[i] | (q[i] & ~clr);
      end
   end
endmodule

// File: rtl/hbctl_top.sv
module hbctl_top
   import hbctl_pkg::*;
#(
   parameter int N_BRIDGE = 3,
   parameter int FRAME_W = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  sck,
   input  logic                  sdi,
   output logic                  sdo,
   output logic                  sdo_en,
   output logic [N_BRIDGE-1:0]   ls_on,
   output logic [N_BRIDGE-1:0]   hs_on,
   output logic                  ocs_en,
   input  logic                  sc_evt,
   input  logic                  ol_evt,
   input  logic                  psf_evt,
   input  logic                  temp_warn,
   input  logic [2*N_BRIDGE-1:0] out_fb
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam int BR_TOP = CMD_BR_BASE + 2*N_BRIDGE - 1;

   if (FRAME_W != WORD_W) begin : g_bad_w
      $error("hbctl_top: FRAME_W must equal the 16-bit word layout");
   end
   if (BR_TOP > CMD_LAST_FREE || N_BRIDGE < 1) begin : g_bad_n
      $error("hbctl_top: N_BRIDGE does not fit the command word");
   end

   // synchronize the serial pins and detect their edges
   logic [2:0] sync_q;
   logic cs_s, sck_s, sdi_s, cs_d, sck_d;
   logic cs_fall, cs_rise, sck_fall, sck_rise;

   hbctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(sync_q)
   );
   assign {cs_s, sck_s, sdi_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end
   assign cs_fall  = cs_d & ~cs_s;
   assign cs_rise  = ~cs_d & cs_s;
   assign sck_fall = sck_d & ~sck_s;
   assign sck_rise = ~sck_d & sck_s;

   // status word assembly
   logic [N_FAULT-1:0] flt_q, flt_evt;
   logic [FRAME_W-1:0] st_word;
   assign flt_evt = {psf_evt, ol_evt, sc_evt};

   always_comb begin
      st_word = '0;
      st_word[ST_TEMP] = temp_warn;
      for (int k = 0; k < 2*N_BRIDGE; k++) st_word[ST_FB_BASE+k] = out_fb[k];
      st_word[ST_SC]  = flt_q[0];
      st_word[ST_OL]  = flt_q[1];
      st_word[ST_PSF] = flt_q[2];
   end

   // frame shifter
   logic [FRAME_W-1:0] rx_word;
   logic [CNT_W-1:0]   bit_cnt;
   logic               active;

   hbctl_shifter #(.W(FRAME_W), .CW(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sck_fall(sck_fall), .sck_rise(sck_rise),
      .sdi_s(sdi_s), .status_in(st_word),
      .rx_word(rx_word), .bit_cnt(bit_cnt),
      .sdo(sdo), .active(active)
   );
   assign sdo_en = active;

   logic commit, st_clr;
   assign commit = cs_rise & active & (bit_cnt == CNT_W'(FRAME_W));
   assign st_clr = commit & rx_word[CMD_CLR];

   hbctl_sticky #(.N(N_FAULT)) u_flt (
      .clk(clk), .rst_n(rst_n), .set(flt_evt), .clr(st_clr), .q(flt_q)
   );

   // per-bridge decode with shoot-through guard
   logic [N_BRIDGE-1:0] nxt_ls, nxt_hs;
   for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
      logic lo_req, hi_req;
      assign lo_req = rx_word[CMD_BR_BASE + 2*b];
      assign hi_req = rx_word[CMD_BR_BASE + 2*b + 1];
      assign nxt_ls[b] = lo_req & ~hi_req;
      assign nxt_hs[b] = hi_req & ~lo_req;
   end

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{rx_word[FRAME_W-1:CMD_OCS+1], rx_word[CMD_OCS-1:BR_TOP+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_on  <= '0;
         hs_on  <= '0;
         ocs_en <= 1'b0;
      end else if (commit) begin
         ls_on  <= nxt_ls;
         hs_on  <= nxt_hs;
         ocs_en <= rx_word[CMD_OCS];
      end
   end
endmodule

// File: rtl/hbctl_check.sv
module hbctl_check #(
   parameter int N = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] ls_on,
   input logic [N-1:0] hs_on,
   input logic         ocs_en,
   input logic         sdo,
   input logic         sdo_en,
   input logic         cs_fall,
   input logic         sck_rise,
   input logic         commit,
   input logic         st_clr,
   input logic [2:0]   flt_q,
   input logic [2:0]   flt_evt
);
   p_no_shoot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_on & hs_on) == '0);

   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ls_on, hs_on, ocs_en}) |-> $past(commit));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !st_clr |=> (($past(flt_q) & ~flt_q) == 3'b000));

   p_evt_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_evt != 3'b000) |=> (($past(flt_evt) & ~flt_q) == 3'b000));

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr && flt_evt == 3'b000) |=> (flt_q == 3'b000));

   p_tri_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_en) |-> $past(cs_fall));

   p_do_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && $past(sdo_en) && !$stable(sdo)) |-> $past(sck_rise));
endmodule

bind hbctl_top hbctl_check #(.N(N_BRIDGE)) u_chk (
   .clk(clk), .rst_n(rst_n), .ls_on(ls_on), .hs_on(hs_on), .ocs_en(ocs_en),
   .sdo(sdo), .sdo_en(sdo_en), .cs_fall(cs_fall), .sck_rise(sck_rise),
   .commit(commit), .st_clr(st_clr), .flt_q(flt_q), .flt_evt(flt_evt)
);

// File: tb/hbctl_top_test.sv
`timescale 1ns/1ps
module hbctl_top_test;
   localparam int SYNC = 2;
   localparam int H = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sc_evt = 1'b0, ol_evt = 1'b0, psf_evt = 1'b0, temp_warn = 1'b0;
   logic [5:0] out_fb = '0;
   logic sdo, sdo_en, ocs_en;
   logic [2:0] ls_on, hs_on;

   int total = 0, bad = 0;
   logic [2:0] m_ls = '0, m_hs = '0, m_flt = '0;
   logic m_ocs = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hbctl_top #(.SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_en(sdo_en), .ls_on(ls_on), .hs_on(hs_on), .ocs_en(ocs_en),
      .sc_evt(sc_evt), .ol_evt(ol_evt), .psf_evt(psf_evt),
      .temp_warn(temp_warn), .out_fb(out_fb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model for the outputs, compared on every clock (R3)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({ls_on, hs_on, ocs_en} == {m_ls, m_hs, m_ocs}, "R3 outputs",
             {ls_on, hs_on, ocs_en}, {m_ls, m_hs, m_ocs});
      end
   end

   function automatic logic [15:0] exp_status();
      logic [15:0] s = '0;
      s[0] = temp_warn;
      for (int k = 0; k < 6; k++) s[1+k] = out_fb[k];
      s[13] = m_flt[0];
      s[14] = m_flt[1];
      s[15] = m_flt[2];
      return s;
   endfunction

   task automatic apply_cmd(input logic [15:0] c);
      for (int b = 0; b < 3; b++) begin
         m_ls[b] = c[1+2*b] && !c[2+2*b];
         m_hs[b] = c[2+2*b] && !c[1+2*b];
      end
      m_ocs = c[13];
   endtask

   task automatic frame(input logic [31:0] cmd, input int nbits, input logic [2:0] inj,
                        output logic [15:0] got, output logic [15:0] exp);
      @(negedge clk);
      chk(sdo_en == 1'b0, "R9 idle", sdo_en, 0);
      exp = exp_status();
      got = '0;
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi = cmd[i];
         sck = 1'b1;
         repeat (H) @(negedge clk);
         if (i < 16) got[i] = sdo;
         sck = 1'b0;
         repeat (H) @(negedge clk);
      end
      chk(sdo_en == 1'b1, "R9 active", sdo_en, 1);
      cs_n = 1'b1;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      {psf_evt, ol_evt, sc_evt} = inj;
      @(posedge clk);
      if (nbits == 16) begin
         apply_cmd(cmd[15:0]);
         if (cmd[0]) m_flt = '0;
      end
      m_flt = m_flt | inj;
      @(negedge clk);
      {psf_evt, ol_evt, sc_evt} = 3'b000;
      repeat (H) @(negedge clk);
      chk(sdo_en == 1'b0, "R9 released", sdo_en, 0);
   endtask

   task automatic pulse(input logic [2:0] m);
      @(negedge clk);
      {psf_evt, ol_evt, sc_evt} = m;
      @(posedge clk);
      m_flt = m_flt | m;
      @(negedge clk);
      {psf_evt, ol_evt, sc_evt} = 3'b000;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] g, e;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({ls_on, hs_on, ocs_en} == 7'd0, "R1 switches", {ls_on, hs_on, ocs_en}, 0);
      chk(sdo_en == 1'b0, "R1 sdo_en", sdo_en, 0);
      frame(32'h0, 16, 3'b000, g, e);
      chk(g == 16'h0000, "R1 latches", g, 0);

      // R2 bit mapping: LS1, HS2, LS3
      frame(32'h0032, 16, 3'b000, g, e);
      chk(ls_on == 3'b101 && hs_on == 3'b010, "R2 map", {ls_on, hs_on}, 6'b101010);

      // R6 overcurrent enable with HS1, HS3
      frame(32'h2044, 16, 3'b000, g, e);
      chk(ocs_en == 1'b1, "R6 ocs", ocs_en, 1);
      chk(hs_on == 3'b101 && ls_on == 3'b000, "R2 high sides", {ls_on, hs_on}, 6'b000101);

      // R5 both switches of bridge 0 requested
      frame(32'h0046, 16, 3'b000, g, e);
      chk(ls_on == 3'b000 && hs_on == 3'b100, "R5 shoot-through", {ls_on, hs_on}, 6'b000100);

      // R7 unused bits with LS2
      frame(32'hDF88, 16, 3'b000, g, e);
      chk(ls_on == 3'b010 && hs_on == 3'b000 && !ocs_en, "R7 ignored",
          {ls_on, hs_on, ocs_en}, 7'b0100000);

      // R4 short and long frames are discarded
      frame(32'h0002, 15, 3'b000, g, e);
      chk(ls_on == 3'b010, "R4 short frame", ls_on, 3'b010);
      frame(32'h0002, 17, 3'b000, g, e);
      chk(ls_on == 3'b010, "R4 long frame", ls_on, 3'b010);

      // R8 and R10 status readback with latched faults
      temp_warn = 1'b1;
      out_fb = 6'b101001;
      pulse(3'b001);
      pulse(3'b100);
      frame(32'h0, 16, 3'b000, g, e);
      chk(g == e, "R8 status word", g, e);
      chk(g[13] && g[15] && !g[14], "R10 latched", g, 16'hA000);
      out_fb = 6'b010110;
      temp_warn = 1'b0;
      frame(32'h0, 16, 3'b000, g, e);
      chk(g == e, "R10 still set", g, e);

      // R11 clear command
      frame(32'h0001, 16, 3'b000, g, e);
      chk(g == e, "R11 readback before clear", g, e);
      frame(32'h0, 16, 3'b000, g, e);
      chk(g[15:13] == 3'b000, "R11 cleared", g[15:13], 0);

      // R12 fault in the same cycle as the clear
      pulse(3'b010);
      frame(32'h0001, 16, 3'b001, g, e);
      frame(32'h0, 16, 3'b000, g, e);
      chk(g[15:13] == 3'b001, "R12 new fault wins", g[15:13], 3'b001);
      chk(g == e, "R8 status after clear", g, e);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule